// File: doc/BRIEF.md
# Rotating Register File With Constant Region

This block is a small register file for a datapath that runs a modulo-scheduled loop. It has one write port and two read ports. Each cycle, the configuration word for the current schedule phase supplies the logical write address, the write enable and both logical read addresses. The block keeps its own phase counter, which steps from 0 up to the initiation interval minus one and then wraps. Each wrap ends one pass through the schedule and advances a wave counter.

The wave count is added to every logical address that falls in the lower, rotating part of the file. The sum wraps modulo the size of that part, so each new iteration writes the same logical register into a fresh physical entry. A value therefore survives later passes without being copied. A boundary set at configuration time marks every entry at or above it as a constant region. Addresses in that region ignore the wave count. The constant region is written only while configuration is being loaded. A scheduled write aimed at it is dropped and raises a sticky error flag.

The write and the two reads in the same cycle use the same mapping. A read of the entry being written returns the contents from before the write.

Top module: `rrf_const_top`

## Requirements
- R1: After reset the phase output is 0, the wave count is 0, the error flag is 0, all entries hold zero, the rotating size equals DEPTH and the initiation interval is 1.
- R2: While cfg_en is 1, a cfg_we write stores cfg_wdata at physical entry cfg_addr, with no mapping applied. Each such cycle latches the rotating size as the smaller of cfg_rot and DEPTH, and the interval as cfg_ii, with 0 read as 1. It also clears the phase and the wave count to 0, and the scheduled write port is ignored.
- R3: While run is 1 and cfg_en is 0, the phase steps by one each cycle and goes back to 0 after the value interval-1. On that wrap the wave count advances by one modulo the rotating size. It stays 0 when the rotating size is 0 or 1.
- R4: A logical address L below the rotating size R maps to physical entry (L + wave) mod R. This mapping is the same for the write port and both read ports.
- R5: A logical address at or above R maps to the physical entry of the same number, whatever the wave count. With R = 0 every address is constant.
- R6: A scheduled write (run=1, cfg_en=0, wr_en=1) whose logical address is at or above R changes no entry and sets const_wr_err. The flag stays set until reset.
- R7: A value written to logical L during wave w is not touched by the write to logical L during wave w+1. During wave w+k it reads back at logical (L - k) mod R, until R waves have passed.
- R8: The read data ports are combinational. Reading the entry that is written in the same cycle returns the old contents, and the new value appears from the next cycle on.
- R9: The two read ports are independent and may address any entries, including the same one.
- R10: With run=0 and cfg_en=0, the phase and wave count hold and wr_en has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration load mode |
| cfg_we | input | 1 | Load write enable (physical address) |
| cfg_addr | input | AW | Physical entry written during load |
| cfg_wdata | input | WIDTH | Data written during load |
| cfg_rot | input | AW+1 | Rotating region size, clamped to DEPTH |
| cfg_ii | input | PW | Initiation interval in cycles, 0 read as 1 |
| run | input | 1 | Schedule advances this cycle |
| wr_en | input | 1 | Scheduled write enable for this phase |
| wr_addr | input | AW | Scheduled logical write address |
| wr_data | input | WIDTH | Scheduled write data |
| rd0_addr | input | AW | Logical address, read port 0 |
| rd1_addr | input | AW | Logical address, read port 1 |
| rd0_data | output | WIDTH | Read data, port 0 (combinational) |
| rd1_data | output | WIDTH | Read data, port 1 (combinational) |
| phase | output | PW | Current schedule phase |
| const_wr_err | output | 1 | Sticky flag for a blocked constant-region write |

## Verification
Read data is due in the same cycle as its address, before the next edge, and it reflects every write up to the previous edge. The phase, the wave count, the error flag and the stored contents change one edge after the cycle that causes them. The bench applies each cycle's inputs at the falling edge and compares both read ports, the phase and the flag one time unit later against a model that is updated only after the rising edge. A read-before-write check and its follow-up read therefore fall on the two sides of the same edge.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_LOAD,
        WR_SCHED,
        WR_BLOCKED
    } wr_src_e;

    // Logical to physical mapping: rotate below the boundary, identity above.
    function automatic int unsigned map_addr(int unsigned log_a,
                                             int unsigned wave,
                                             int unsigned rot);
        int unsigned sum;
        if (rot == 0 || log_a >= rot) begin
            return log_a;
        end
        sum = log_a + wave;
        if (sum >= rot) begin
            sum = sum - rot;
        end
        return sum;
    endfunction

    // Wave count after one wrap of the schedule.
    function automatic int unsigned step_wave(int unsigned wave, int unsigned rot);
        if (rot <= 1) begin
            return 0;
        end
        if (wave + 1 >= rot) begin
            return 0;
        end
        return wave + 1;
    endfunction

endpackage

// File: rtl/rrf_wave_ctr.sv
module rrf_wave_ctr
    import rrf_pkg::*;
#(
    parameter int AW = 2,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          run,
    input  logic [PW-1:0] ii,
    input  logic [AW:0]   rot,
    output logic [PW-1:0] phase,
    output logic [AW-1:0] wave
);

    logic last_phase;

    assign last_phase = (({1'b0, phase} + 1'b1) >= {1'b0, ii});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= '0;
            wave  <= '0;
        end else if (run) begin
            if (last_phase) begin
                phase <= '0;
                wave  <= AW'(step_wave(32'(wave), 32'(rot)));
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rrf_addr_map.sv
module rrf_addr_map
    import rrf_pkg::*;
#(
    parameter int AW = 2
) (
    input  logic [AW-1:0] log_addr,
    input  logic [AW-1:0] wave,
    input  logic [AW:0]   rot,
    output logic [AW-1:0] phys_addr,
    output logic          in_const
);

    assign in_const  = ({1'b0, log_addr} >= rot);
    assign phys_addr = AW'(map_addr(32'(log_addr), 32'(wave), 32'(rot)));

endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32,
    parameter int AW    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr0,
    input  logic [AW-1:0]    raddr1,
    output logic [WIDTH-1:0] rdata0,
    output logic [WIDTH-1:0] rdata1
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [DEPTH-1:0] hit;

    for (genvar e = 0; e < DEPTH; e++) begin : g_dec
        assign hit[e] = we && (waddr == AW'(e));
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (rst) begin
                mem[e] <= '0;
            end else if (hit[e]) begin
                mem[e] <= wdata;
            end
        end
    end

    assign rdata0 = mem[raddr0];
    assign rdata1 = mem[raddr1];

endmodule

// File: rtl/rrf_const_top.sv
module rrf_const_top
    import rrf_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int WIDTH  = 32,
    parameter int MAX_II = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = $clog2(MAX_II) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [WIDTH-1:0] cfg_wdata,
    input  logic [AW:0]      cfg_rot,
    input  logic [PW-1:0]    cfg_ii,
    input  logic             run,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd0_addr,
    input  logic [AW-1:0]    rd1_addr,
    output logic [WIDTH-1:0] rd0_data,
    output logic [WIDTH-1:0] rd1_data,
    output logic [PW-1:0]    phase,
    output logic             const_wr_err
);

    localparam int NPORT = 3;   // 0,1 read; 2 write

    logic [AW:0]      rot_q;
    logic [PW-1:0]    ii_q;
    logic [PW-1:0]    phase_q;
    logic [AW-1:0]    wave_q;
    logic             err_q;
    logic [AW-1:0]    log_a  [NPORT];
    logic [AW-1:0]    phys_a [NPORT];
    logic             cst_a  [NPORT];
    wr_src_e          wsrc;
    logic             mem_we;
    logic [AW-1:0]    mem_waddr;
    logic [WIDTH-1:0] mem_wdata;

    // configuration latches
    always_ff @(posedge clk) begin
        if (rst) begin
            rot_q <= (AW+1)'(DEPTH);
            ii_q  <= PW'(1);
        end else if (cfg_en) begin
            rot_q <= (cfg_rot > (AW+1)'(DEPTH)) ? (AW+1)'(DEPTH) : cfg_rot;
            ii_q  <= (cfg_ii == '0) ? PW'(1) : cfg_ii;
        end
    end

    rrf_wave_ctr #(.AW(AW), .PW(PW)) wave_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (cfg_en),
        .run   (run),
        .ii    (ii_q),
        .rot   (rot_q),
        .phase (phase_q),
        .wave  (wave_q)
    );

    assign log_a[0] = rd0_addr;
    assign log_a[1] = rd1_addr;
    assign log_a[2] = wr_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rrf_addr_map #(.AW(AW)) map_i (
            .log_addr  (log_a[p]),
            .wave      (wave_q),
            .rot       (rot_q),
            .phys_addr (phys_a[p]),
            .in_const  (cst_a[p])
        );
    end

    // write source selection
    always_comb begin
        if (cfg_en) begin
            wsrc = cfg_we ? WR_LOAD : WR_NONE;
        end else if (run && wr_en) begin
            wsrc = cst_a[2] ? WR_BLOCKED : WR_SCHED;
        end else begin
            wsrc = WR_NONE;
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = phys_a[2];
        mem_wdata = wr_data;
        unique case (wsrc)
            WR_LOAD: begin
                mem_we    = 1'b1;
                mem_waddr = cfg_addr;
                mem_wdata = cfg_wdata;
            end
            WR_SCHED: mem_we = 1'b1;
            default:  mem_we = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (wsrc == WR_BLOCKED) begin
            err_q <= 1'b1;
        end
    end

    rrf_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) store_i (
        .clk    (clk),
        .rst    (rst),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .raddr0 (phys_a[0]),
        .raddr1 (phys_a[1]),
        .rdata0 (rd0_data),
        .rdata1 (rd1_data)
    );

    assign phase        = phase_q;
    assign const_wr_err = err_q;

endmodule

// File: rtl/rrf_checks.sv
module rrf_checks #(
    parameter int AW = 2,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_en,
    input logic          run,
    input logic          wr_en,
    input logic          w_const,
    input logic [PW-1:0] phase,
    input logic [PW-1:0] ii,
    input logic [AW-1:0] wave,
    input logic [AW:0]   rot,
    input logic          err
);

    assert_phase_range_R3: assert property (@(posedge clk) disable iff (rst)
        phase < ii);

    assert_phase_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && run && (phase == ii - 1'b1)) |=> (phase == '0));

    assert_wave_range_R4: assert property (@(posedge clk) disable iff (rst)
        ((rot <= 1) ? (wave == '0) : ({1'b0, wave} < rot)));

    assert_cfg_clears_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (phase == '0 && wave == '0));

    assert_const_write_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && run && wr_en && w_const) |=> err);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !run) |=> ($stable(phase) && $stable(wave)));

endmodule

bind rrf_const_top rrf_checks #(.AW(AW), .PW(PW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .cfg_en  (cfg_en),
    .run     (run),
    .wr_en   (wr_en),
    .w_const (cst_a[2]),
    .phase   (phase_q),
    .ii      (ii_q),
    .wave    (wave_q),
    .rot     (rot_q),
    .err     (err_q)
);

// File: tb/rrf_const_top_tb_top.sv
module rrf_const_top_tb_top;

    localparam int DEPTH  = 4;
    localparam int WIDTH  = 32;
    localparam int MAX_II = 8;
    localparam int AW     = $clog2(DEPTH);
    localparam int PW     = $clog2(MAX_II) + 1;
    localparam int CLK_P  = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_en, cfg_we;
    logic [AW-1:0]    cfg_addr;
    logic [WIDTH-1:0] cfg_wdata;
    logic [AW:0]      cfg_rot;
    logic [PW-1:0]    cfg_ii;
    logic             run, wr_en;
    logic [AW-1:0]    wr_addr, rd0_addr, rd1_addr;
    logic [WIDTH-1:0] wr_data;
    logic [WIDTH-1:0] rd0_data, rd1_data;
    logic [PW-1:0]    phase;
    logic             const_wr_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model
    logic [WIDTH-1:0] m_mem [DEPTH];
    int m_wave, m_phase, m_rot, m_ii;
    bit m_err;

    always #(CLK_P/2) clk = ~clk;

    rrf_const_top #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MAX_II(MAX_II)) dut_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rot(cfg_rot),
        .cfg_ii(cfg_ii), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd0_addr(rd0_addr), .rd1_addr(rd1_addr),
        .rd0_data(rd0_data), .rd1_data(rd1_data), .phase(phase),
        .const_wr_err(const_wr_err)
    );

    function automatic int exp_phys(int la);
        if (m_rot == 0 || la >= m_rot) return la;
        return (la + m_wave) % m_rot;
    endfunction

    task automatic check(input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp,
                         input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // compare outputs (inputs already applied), then update model at the edge
    task automatic tick();
        int wp;
        #1;
        check(rd0_data, m_mem[exp_phys(int'(rd0_addr))], "R4", "read port 0");
        check(rd1_data, m_mem[exp_phys(int'(rd1_addr))], "R9", "read port 1");
        check(32'(phase), 32'(m_phase), "R3", "phase");
        check(32'(const_wr_err), 32'(m_err), "R6", "error flag");
        @(posedge clk);
        if (cfg_en) begin
            if (cfg_we) m_mem[int'(cfg_addr)] = cfg_wdata;
            m_rot   = (int'(cfg_rot) > DEPTH) ? DEPTH : int'(cfg_rot);
            m_ii    = (cfg_ii == 0) ? 1 : int'(cfg_ii);
            m_phase = 0;
            m_wave  = 0;
        end else if (run) begin
            if (wr_en) begin
                if (m_rot == 0 || int'(wr_addr) >= m_rot) m_err = 1'b1;
                else begin
                    wp = exp_phys(int'(wr_addr));
                    m_mem[wp] = wr_data;
                end
            end
            if (m_phase + 1 >= m_ii) begin
                m_phase = 0;
                m_wave  = (m_rot <= 1 || m_wave + 1 >= m_rot) ? 0 : m_wave + 1;
            end else begin
                m_phase = m_phase + 1;
            end
        end
    endtask

    task automatic sched_op(input bit r, input bit we, input int wa,
                            input logic [WIDTH-1:0] wd, input int a0, input int a1);
        @(negedge clk);
        cfg_en = 1'b0; cfg_we = 1'b0;
        run = r; wr_en = we; wr_addr = wa[AW-1:0]; wr_data = wd;
        rd0_addr = a0[AW-1:0]; rd1_addr = a1[AW-1:0];
        tick();
    endtask

    task automatic cfg_op(input bit we, input int a, input logic [WIDTH-1:0] d,
                          input int rot, input int ii);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = we; cfg_addr = a[AW-1:0]; cfg_wdata = d;
        cfg_rot = rot[AW:0]; cfg_ii = ii[PW-1:0];
        run = 1'b1; wr_en = 1'b1; wr_addr = a[AW-1:0]; wr_data = 32'hBAD0_BAD0;
        rd0_addr = '0; rd1_addr = '0;
        tick();
    endtask

    // idle inputs and settle, no edge consumed
    task automatic peek(input int a0, input int a1);
        @(negedge clk);
        cfg_en = 1'b0; cfg_we = 1'b0; run = 1'b0; wr_en = 1'b0;
        rd0_addr = a0[AW-1:0]; rd1_addr = a1[AW-1:0];
        #1;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    localparam logic [WIDTH-1:0] K = 32'hC0DE_0003;
    localparam logic [WIDTH-1:0] A = 32'hAAAA_0001;
    localparam logic [WIDTH-1:0] B = 32'hBBBB_0002;

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; cfg_en = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
        cfg_rot = '0; cfg_ii = '0; run = 0; wr_en = 0; wr_addr = '0;
        wr_data = '0; rd0_addr = '0; rd1_addr = '0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_wave = 0; m_phase = 0; m_rot = DEPTH; m_ii = 1; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        peek(0, 3);
        check(rd0_data, '0, "R1", "entry 0 after reset");
        check(rd1_data, '0, "R1", "entry 3 after reset");
        check(32'(phase), 0, "R1", "phase after reset");
        check(32'(const_wr_err), 0, "R1", "flag after reset");

        // R2: load, rot=3 (entries 0..2 rotate, 3 constant), ii=2
        cfg_op(1, 3, K, 3, 2);
        cfg_op(1, 0, 32'h0000_0011, 3, 2);
        cfg_op(1, 1, 32'h0000_0022, 3, 2);
        cfg_op(1, 2, 32'h0000_0033, 3, 2);
        peek(3, 0);
        check(rd0_data, K, "R2", "loaded constant entry");
        check(rd1_data, 32'h0000_0011, "R2", "load ignores scheduled write");

        // wave 0: write logical 0 = A (physical 0)
        sched_op(1, 1, 0, A, 1, 2);
        peek(0, 0);
        check(32'(phase), 1, "R3", "phase after one run cycle");
        sched_op(1, 0, 0, '0, 0, 0);
        peek(0, 0);
        check(32'(phase), 0, "R3", "phase wraps at interval");
        // wave 1: logical 0 -> physical 1 (old 0x22); logical 2 -> physical 0 (A)
        sched_op(1, 1, 0, B, 0, 2);
        // the read in that cycle saw the old value; compare explicitly too
        peek(0, 2);
        check(rd0_data, B, "R8", "new value visible next cycle");
        check(rd1_data, A, "R7", "older iteration value survives rename");
        peek(3, 3);
        check(rd0_data, K, "R5", "constant unaffected by wave");

        // read-before-write at the same physical entry
        @(negedge clk);
        cfg_en = 0; run = 1; wr_en = 1; wr_addr = 2'd1; wr_data = 32'h7777_0007;
        rd0_addr = 2'd1; rd1_addr = 2'd1;
        #1;
        check(rd0_data, 32'h0000_0033, "R8", "same-cycle read returns old data");
        tick();
        // now wave 2 (phase wrapped); logical 1 -> physical 0 = A
        // scheduled write into the constant region
        sched_op(1, 1, 3, 32'hDEAD_BEEF, 3, 0);
        peek(3, 3);
        check(rd0_data, K, "R6", "constant entry unchanged");
        check(32'(const_wr_err), 1, "R6", "flag set by blocked write");

        // R10: idle cycle ignores writes
        begin
            int ph0;
            int ex;
            ph0 = m_phase;
            ex  = exp_phys(1);
            sched_op(0, 1, 1, 32'h5555_5555, 1, 1);
            peek(1, 1);
            check(32'(phase), 32'(ph0), "R10", "phase held while idle");
            check(rd0_data, m_mem[ex], "R10", "entry untouched while idle");
        end

        // R5: rot=0, everything constant
        cfg_op(0, 0, '0, 0, 1);
        sched_op(1, 1, 1, 32'h1234_5678, 1, 2);
        sched_op(1, 0, 0, '0, 1, 2);
        peek(1, 2);
        check(rd0_data, m_mem[1], "R5", "no rotation with empty rotating region");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 3) begin
                cfg_op(1, int'($urandom_range(0, DEPTH-1)), $urandom(),
                       int'($urandom_range(0, DEPTH+2)), int'($urandom_range(0, 5)));
            end else begin
                sched_op(r < 90, $urandom_range(0, 1) == 1,
                         int'($urandom_range(0, DEPTH-1)), $urandom(),
                         int'($urandom_range(0, DEPTH-1)), int'($urandom_range(0, DEPTH-1)));
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule